// File: doc/BRIEF.md
# Trap Entry and Vector Unit

This unit performs the work a processor core does when it takes a trap. A single-cycle strobe delivers a 9-bit trap type together with a snapshot of the architectural state: program counter and next program counter, condition codes, address space identifier, the processor-state bits, the current window pointer, the count of windows that can still be saved, the trap base address, the current trap level and the configured maximum trap level. One cycle later, all the consequences of the trap commit together.

The unit packs the condition codes, ASI, the saveable processor-state bits and the window pointer into one saved-state word. It writes that word, the old PC, the old NPC and the trap type into an internal trap stack slot chosen by the new trap level. It raises the trap level and enters the reset/error-recovery (RED) mode on the last legal level. It rewrites the processor-state bits to the privileged set that matches the trap class. For window spill, fill and clean-window traps it moves the window pointer. Finally it forms the vector PC and NPC. A trap that arrives when the level is already at the limit changes nothing and raises an error flag. A read port exposes any stack slot to the trap-return path.

Top module: `trap_entry_unit`

## Requirements
- R1: A trap is taken when `trap_valid` is high for one clock. All outputs update on the next rising edge, and `trap_done` is high for exactly that one cycle. Without a strobe, `trap_done` stays low and the outputs hold.
- R2: If `cur_tl >= max_tl` when the strobe arrives, `err_state` and `trap_done` go high. The new_* outputs equal the current inputs, and no stack slot is written. Otherwise `err_state` is low.
- R3: An accepted trap sets `new_tl = cur_tl + 1`. When `cur_tl + 1 == max_tl`, bit 5 (RED) of `new_pstate` is set.
- R4: The saved-state word is 40 bits wide. Bits 39:32 hold CCR, bits 31:24 hold ASI, bits 19:8 hold `cur_pstate & 12'hF3F`, bits 2:0 hold CWP, and all other bits are zero.
- R5: An accepted trap writes the stack slot `new_tl mod 8` with the state word, the old PC, the old NPC and the trap type. `ts_rd_*` shows the slot selected by `ts_rd_idx` combinationally.
- R6: On an accepted trap, `new_pstate` keeps only PEF (bit 4), PRIV (bit 2), one global-set bit, and RED (bit 5) when R3 applies; all other bits are zero. The global-set bit is chosen by trap type: 0x060 selects interrupt globals (bit 11). 0x008, 0x030 and 0x064 through 0x06F select MMU globals (bit 10). Every other type selects alternate globals (bit 0).
- R7: Trap type 0x024 (clean window) gives `new_cwp = cur_cwp - 1` modulo 8.
- R8: Types 0x080 to 0x0BF (spill) give `new_cwp = cur_cwp - cur_cansave - 2` modulo 8. Types 0x0C0 to 0x0FF (fill) give `cur_cwp + 1` modulo 8. All other types leave CWP unchanged.
- R9: `new_pc` is `cur_tba` with bits 14:0 cleared, with bit 14 set when the new level exceeds 1, and with the trap type placed in bits 13:5.
- R10: `new_npc = new_pc + 4` on an accepted trap.
- R11: After reset, every output and every stack slot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_valid | input | 1 | One-cycle trap strobe |
| trap_tt | input | 9 | Trap type |
| cur_pc | input | 64 | Current PC |
| cur_npc | input | 64 | Current next PC |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address space identifier |
| cur_pstate | input | 12 | Processor-state bits |
| cur_cwp | input | 3 | Current window pointer |
| cur_cansave | input | 3 | Windows still saveable |
| cur_tba | input | 64 | Trap base address |
| cur_tl | input | 3 | Current trap level |
| max_tl | input | 3 | Maximum trap level |
| ts_rd_idx | input | 3 | Trap stack read slot |
| new_pc | output | 64 | Vector PC |
| new_npc | output | 64 | Vector next PC |
| new_pstate | output | 12 | Updated processor-state bits |
| new_cwp | output | 3 | Updated window pointer |
| new_tl | output | 3 | Updated trap level |
| err_state | output | 1 | Trap taken at the level limit |
| trap_done | output | 1 | Commit pulse |
| ts_rd_state | output | 40 | Saved-state word of read slot |
| ts_rd_pc | output | 64 | Saved PC of read slot |
| ts_rd_npc | output | 64 | Saved NPC of read slot |
| ts_rd_tt | output | 9 | Saved trap type of read slot |

## Verification
Entering RED mode on the last legal level can coincide with a window trap, and both then act in the same commit. The bench provokes this with spill, fill and clean-window types issued at `cur_tl = max_tl - 1`, both directed and within the random mix. Each such trap is judged by comparing the RED bit, the wrapped window pointer, the vector bit 14 and the stack slot against the bench's model in that commit cycle. The neighbouring error case (`cur_tl = max_tl`) is checked in the same way, to confirm that nothing moves and the stack slot is left untouched.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
    localparam int TT_W  = 9;
    localparam int CCR_W = 8;
    localparam int ASI_W = 8;
    localparam int PST_W = 12;
    localparam int SW_W  = 40;

    localparam logic [TT_W-1:0] TT_CLEAN_WIN  = 9'h024;
    localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
    localparam logic [TT_W-1:0] TT_FILL_BASE  = 9'h0C0;
    localparam logic [TT_W-1:0] TT_WIN_MASK   = 9'h1C0;
    localparam logic [TT_W-1:0] TT_INT_VEC    = 9'h060;
    localparam logic [TT_W-1:0] TT_IACC_FAULT = 9'h008;
    localparam logic [TT_W-1:0] TT_DACC_FAULT = 9'h030;
    localparam logic [TT_W-1:0] TT_MMU_LO     = 9'h064;
    localparam logic [TT_W-1:0] TT_MMU_HI     = 9'h06F;

    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam int PS_MG   = 10;
    localparam int PS_IG   = 11;
    localparam logic [PST_W-1:0] PS_SAVE_MASK = 12'hF3F;

    typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
    typedef enum logic [1:0] {WOP_NONE, WOP_CLEAN, WOP_SPILL, WOP_FILL} wop_e;
endpackage

// File: rtl/trap_classify.sv
module trap_classify
    import trap_entry_pkg::*;
(
    input  logic [TT_W-1:0] tt,
    output gsel_e           gsel,
    output wop_e            wop
);
    logic is_mmu;

    always_comb begin
        is_mmu = (tt == TT_IACC_FAULT) || (tt == TT_DACC_FAULT) ||
                 ((tt >= TT_MMU_LO) && (tt <= TT_MMU_HI));
        if (tt == TT_INT_VEC)  gsel = GSEL_INT;
        else if (is_mmu)       gsel = GSEL_MMU;
        else                   gsel = GSEL_ALT;

        if (tt == TT_CLEAN_WIN)                          wop = WOP_CLEAN;
        else if ((tt & TT_WIN_MASK) == TT_SPILL_BASE)    wop = WOP_SPILL;
        else if ((tt & TT_WIN_MASK) == TT_FILL_BASE)     wop = WOP_FILL;
        else                                             wop = WOP_NONE;
    end
endmodule

// File: rtl/trap_window.sv
module trap_window
    import trap_entry_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] cansave,
    input  wop_e             wop,
    output logic [CWP_W-1:0] cwp_out
);
    localparam int SUM_W = CWP_W + 3;
    logic [SUM_W-1:0] sum;

    always_comb begin
        case (wop)
            WOP_CLEAN: sum = SUM_W'(cwp) + SUM_W'(NWIN - 1);
            WOP_SPILL: sum = SUM_W'(cwp) + SUM_W'(2 * NWIN - 2) - SUM_W'(cansave);
            WOP_FILL:  sum = SUM_W'(cwp) + SUM_W'(1);
            default:   sum = SUM_W'(cwp);
        endcase
        cwp_out = CWP_W'(sum % SUM_W'(NWIN));
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_entry_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int TL_W = 3
) (
    input  logic [VA_W-1:0] tba,
    input  logic [TT_W-1:0] tt,
    input  logic [TL_W-1:0] tl_new,
    output logic [VA_W-1:0] vec_pc,
    output logic [VA_W-1:0] vec_npc
);
    always_comb begin
        vec_pc  = {tba[VA_W-1:15], (tl_new > TL_W'(1)), tt, 5'b00000};
        vec_npc = vec_pc + VA_W'(4);
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int TL_W     = 3,
    parameter int NWIN     = 8,
    parameter int TS_DEPTH = 8,
    localparam int CWP_W   = $clog2(NWIN),
    localparam int IDX_W   = $clog2(TS_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic [TT_W-1:0]    trap_tt,
    input  logic [VA_W-1:0]    cur_pc,
    input  logic [VA_W-1:0]    cur_npc,
    input  logic [CCR_W-1:0]   cur_ccr,
    input  logic [ASI_W-1:0]   cur_asi,
    input  logic [PST_W-1:0]   cur_pstate,
    input  logic [CWP_W-1:0]   cur_cwp,
    input  logic [CWP_W-1:0]   cur_cansave,
    input  logic [VA_W-1:0]    cur_tba,
    input  logic [TL_W-1:0]    cur_tl,
    input  logic [TL_W-1:0]    max_tl,
    input  logic [IDX_W-1:0]   ts_rd_idx,
    output logic [VA_W-1:0]    new_pc,
    output logic [VA_W-1:0]    new_npc,
    output logic [PST_W-1:0]   new_pstate,
    output logic [CWP_W-1:0]   new_cwp,
    output logic [TL_W-1:0]    new_tl,
    output logic               err_state,
    output logic               trap_done,
    output logic [SW_W-1:0]    ts_rd_state,
    output logic [VA_W-1:0]    ts_rd_pc,
    output logic [VA_W-1:0]    ts_rd_npc,
    output logic [TT_W-1:0]    ts_rd_tt
);
    typedef struct packed {
        logic [TS_DEPTH-1:0][SW_W-1:0] stk_sw;
        logic [TS_DEPTH-1:0][VA_W-1:0] stk_pc;
        logic [TS_DEPTH-1:0][VA_W-1:0] stk_npc;
        logic [TS_DEPTH-1:0][TT_W-1:0] stk_tt;
        logic [VA_W-1:0]  pc;
        logic [VA_W-1:0]  npc;
        logic [PST_W-1:0] pst;
        logic [CWP_W-1:0] cwp;
        logic [TL_W-1:0]  tl;
        logic             err;
        logic             done;
    } unit_state_t;

    unit_state_t st_d, st_q;

    gsel_e            gsel;
    wop_e             wop;
    logic [CWP_W-1:0] cwp_nx;
    logic [TL_W-1:0]  tl_nx;
    logic [VA_W-1:0]  vec_pc, vec_npc;
    logic             at_limit, enter_red;
    logic [PST_W-1:0] pst_nx;
    logic [SW_W-1:0]  sw_word;
    logic [IDX_W-1:0] wr_idx;

    trap_classify u_cls (.tt(trap_tt), .gsel(gsel), .wop(wop));

    trap_window #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
        .cwp(cur_cwp), .cansave(cur_cansave), .wop(wop), .cwp_out(cwp_nx)
    );

    trap_vector #(.VA_W(VA_W), .TL_W(TL_W)) u_vec (
        .tba(cur_tba), .tt(trap_tt), .tl_new(tl_nx),
        .vec_pc(vec_pc), .vec_npc(vec_npc)
    );

    always_comb begin
        tl_nx     = cur_tl + TL_W'(1);
        at_limit  = (cur_tl >= max_tl);
        enter_red = ((TL_W+1)'(cur_tl) + (TL_W+1)'(1)) == (TL_W+1)'(max_tl);
        wr_idx    = IDX_W'(tl_nx);

        pst_nx          = '0;
        pst_nx[PS_PEF]  = 1'b1;
        pst_nx[PS_PRIV] = 1'b1;
        pst_nx[PS_RED]  = enter_red;
        case (gsel)
            GSEL_INT: pst_nx[PS_IG] = 1'b1;
            GSEL_MMU: pst_nx[PS_MG] = 1'b1;
            default:  pst_nx[PS_AG] = 1'b1;
        endcase

        sw_word = '0;
        sw_word[39:32] = cur_ccr;
        sw_word[31:24] = cur_asi;
        sw_word[19:8]  = cur_pstate & PS_SAVE_MASK;
        sw_word[CWP_W-1:0] = cur_cwp;

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (trap_valid) begin
            st_d.done = 1'b1;
            if (at_limit) begin
                st_d.err = 1'b1;
                st_d.pc  = cur_pc;
                st_d.npc = cur_npc;
                st_d.pst = cur_pstate;
                st_d.cwp = cur_cwp;
                st_d.tl  = cur_tl;
            end else begin
                st_d.pc  = vec_pc;
                st_d.npc = vec_npc;
                st_d.pst = pst_nx;
                st_d.cwp = cwp_nx;
                st_d.tl  = tl_nx;
                st_d.stk_sw[wr_idx]  = sw_word;
                st_d.stk_pc[wr_idx]  = cur_pc;
                st_d.stk_npc[wr_idx] = cur_npc;
                st_d.stk_tt[wr_idx]  = trap_tt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign new_pc      = st_q.pc;
    assign new_npc     = st_q.npc;
    assign new_pstate  = st_q.pst;
    assign new_cwp     = st_q.cwp;
    assign new_tl      = st_q.tl;
    assign err_state   = st_q.err;
    assign trap_done   = st_q.done;
    assign ts_rd_state = st_q.stk_sw[ts_rd_idx];
    assign ts_rd_pc    = st_q.stk_pc[ts_rd_idx];
    assign ts_rd_npc   = st_q.stk_npc[ts_rd_idx];
    assign ts_rd_tt    = st_q.stk_tt[ts_rd_idx];

    // R1: commit pulse follows the strobe by one cycle
    p_done_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> trap_done);
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !trap_done);

    // R2: a trap at the limit leaves level and PC as they were
    p_err_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && (cur_tl >= max_tl) |=>
            err_state && new_tl == $past(cur_tl) && new_pc == $past(cur_pc));

    // R3: accepted trap raises the level by one, RED on the last level
    p_tl_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && !err_state |-> new_tl == TL_W'($past(cur_tl) + TL_W'(1)));
    p_red_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && !err_state && new_tl == $past(max_tl) |-> new_pstate[PS_RED]);

    // R6: privileged, FP enabled, exactly one global set
    p_priv_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && !err_state |->
            new_pstate[PS_PRIV] && new_pstate[PS_PEF] &&
            $countones({new_pstate[PS_IG], new_pstate[PS_MG], new_pstate[PS_AG]}) == 1);

    // R9: vector carries the trap type in bits 13:5
    p_vec_tt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && !err_state |-> new_pc[4:0] == 5'd0 && new_pc[13:5] == $past(trap_tt));

    // R10: next PC sits one instruction after the vector
    p_npc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && !err_state |-> new_npc == new_pc + VA_W'(4));
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [8:0]  trap_tt = '0;
    logic [63:0] cur_pc = '0, cur_npc = '0, cur_tba = '0;
    logic [7:0]  cur_ccr = '0, cur_asi = '0;
    logic [11:0] cur_pstate = '0;
    logic [2:0]  cur_cwp = '0, cur_cansave = '0, cur_tl = '0, max_tl = 3'd6, ts_rd_idx = '0;
    logic [63:0] new_pc, new_npc, ts_rd_pc, ts_rd_npc;
    logic [11:0] new_pstate;
    logic [2:0]  new_cwp, new_tl;
    logic        err_state, trap_done;
    logic [39:0] ts_rd_state;
    logic [8:0]  ts_rd_tt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [39:0] m_sw  [8];
    logic [63:0] m_pc  [8];
    logic [63:0] m_npc [8];
    logic [8:0]  m_tt  [8];

    always #5 clk = ~clk;

    trap_entry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_tt(trap_tt),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
        .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
        .cur_tba(cur_tba), .cur_tl(cur_tl), .max_tl(max_tl), .ts_rd_idx(ts_rd_idx),
        .new_pc(new_pc), .new_npc(new_npc), .new_pstate(new_pstate), .new_cwp(new_cwp),
        .new_tl(new_tl), .err_state(err_state), .trap_done(trap_done),
        .ts_rd_state(ts_rd_state), .ts_rd_pc(ts_rd_pc), .ts_rd_npc(ts_rd_npc),
        .ts_rd_tt(ts_rd_tt)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_glob(input logic [8:0] tt);
        if (tt == 9'h060) return 12'h800;
        if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) return 12'h400;
        return 12'h001;
    endfunction

    function automatic logic [2:0] exp_cwp(input logic [8:0] tt, input logic [2:0] cwp, input logic [2:0] cs);
        int v;
        if (tt == 9'h024) v = (int'(cwp) + 7) % 8;
        else if ((tt & 9'h1C0) == 9'h080) v = (int'(cwp) + 16 - int'(cs) - 2) % 8;
        else if ((tt & 9'h1C0) == 9'h0C0) v = (int'(cwp) + 1) % 8;
        else v = int'(cwp);
        return v[2:0];
    endfunction

    task automatic do_trap(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] mtl,
                           input logic [2:0] cwp, input logic [2:0] cs);
        logic [63:0] epc, enpc;
        logic [11:0] epst;
        logic [2:0]  ecwp, etl, idx;
        logic        eerr;
        @(negedge clk);
        trap_tt = tt; cur_tl = tl; max_tl = mtl; cur_cwp = cwp; cur_cansave = cs;
        cur_pc = {$urandom, $urandom}; cur_npc = {$urandom, $urandom};
        cur_tba = {$urandom, $urandom}; cur_ccr = 8'($urandom); cur_asi = 8'($urandom);
        cur_pstate = 12'($urandom);
        trap_valid = 1'b1;
        idx  = tl + 3'd1;
        eerr = (tl >= mtl);
        if (eerr) begin
            epc = cur_pc; enpc = cur_npc; epst = cur_pstate; ecwp = cwp; etl = tl;
        end else begin
            etl  = tl + 3'd1;
            epst = 12'h014 | exp_glob(tt) | ((4'(tl) + 4'd1 == 4'(mtl)) ? 12'h020 : 12'h000);
            ecwp = exp_cwp(tt, cwp, cs);
            epc  = {cur_tba[63:15], (etl > 3'd1), tt, 5'd0};
            enpc = epc + 64'd4;
            m_sw[idx]  = {cur_ccr, cur_asi, 4'd0, cur_pstate & 12'hF3F, 5'd0, cwp};
            m_pc[idx]  = cur_pc;
            m_npc[idx] = cur_npc;
            m_tt[idx]  = tt;
        end
        @(negedge clk);
        trap_valid = 1'b0;
        chk(trap_done == 1'b1, "R1 done", 64'(trap_done), 64'd1);
        chk(err_state == eerr, "R2 err", 64'(err_state), 64'(eerr));
        chk(new_tl == etl, "R3 tl", 64'(new_tl), 64'(etl));
        chk(new_pstate == epst, "R6/R3 pstate", 64'(new_pstate), 64'(epst));
        chk(new_cwp == ecwp, "R7/R8 cwp", 64'(new_cwp), 64'(ecwp));
        chk(new_pc == epc, "R9 pc", new_pc, epc);
        chk(new_npc == enpc, "R10 npc", new_npc, enpc);
        ts_rd_idx = idx;
        #1;
        chk(ts_rd_state == m_sw[idx], "R4 state word", 64'(ts_rd_state), 64'(m_sw[idx]));
        chk(ts_rd_pc == m_pc[idx] && ts_rd_npc == m_npc[idx], "R5 saved pc/npc",
            ts_rd_pc, m_pc[idx]);
        chk(ts_rd_tt == m_tt[idx], "R5 saved tt", 64'(ts_rd_tt), 64'(m_tt[idx]));
        @(negedge clk);
        chk(trap_done == 1'b0 && new_tl == etl, "R1 idle hold", 64'(trap_done), 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [8:0] picks [12];
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) begin
            m_sw[i] = '0; m_pc[i] = '0; m_npc[i] = '0; m_tt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(new_pc == 0 && new_npc == 0 && new_pstate == 0 && new_tl == 0 &&
            new_cwp == 0 && !err_state && !trap_done, "R11 outputs", new_pc, 64'd0);
        for (int i = 0; i < 8; i++) begin
            ts_rd_idx = 3'(i);
            #1;
            chk(ts_rd_state == 0 && ts_rd_pc == 0 && ts_rd_npc == 0 && ts_rd_tt == 0,
                "R11 stack", 64'(ts_rd_state), 64'd0);
        end

        // Directed corners
        do_trap(9'h060, 3'd0, 3'd6, 3'd3, 3'd1);   // R6 interrupt globals, tl=1 -> bit14 clear
        do_trap(9'h008, 3'd1, 3'd6, 3'd3, 3'd1);   // R6 mmu, R9 bit14 set
        do_trap(9'h030, 3'd2, 3'd6, 3'd0, 3'd0);   // R6 mmu
        do_trap(9'h063, 3'd0, 3'd6, 3'd4, 3'd2);   // R6 just below mmu group
        do_trap(9'h064, 3'd0, 3'd6, 3'd4, 3'd2);
        do_trap(9'h06F, 3'd0, 3'd6, 3'd4, 3'd2);
        do_trap(9'h070, 3'd0, 3'd6, 3'd4, 3'd2);   // R6 just above
        do_trap(9'h024, 3'd0, 3'd6, 3'd0, 3'd0);   // R7 wrap 0 -> 7
        do_trap(9'h080, 3'd1, 3'd6, 3'd1, 3'd7);   // R8 spill wrap
        do_trap(9'h0BF, 3'd1, 3'd6, 3'd5, 3'd2);
        do_trap(9'h0C0, 3'd1, 3'd6, 3'd7, 3'd0);   // R8 fill wrap 7 -> 0
        do_trap(9'h0FF, 3'd1, 3'd6, 3'd2, 3'd0);
        do_trap(9'h100, 3'd1, 3'd6, 3'd2, 3'd3);   // R8 no window change
        do_trap(9'h090, 3'd5, 3'd6, 3'd0, 3'd6);   // R3 RED with spill in same commit
        do_trap(9'h024, 3'd5, 3'd6, 3'd0, 3'd0);   // R3 RED with clean window
        do_trap(9'h0C4, 3'd6, 3'd6, 3'd6, 3'd0);   // R2 at limit
        do_trap(9'h041, 3'd7, 3'd6, 3'd1, 3'd0);   // R2 above limit
        do_trap(9'h041, 3'd0, 3'd0, 3'd1, 3'd0);   // R2 zero limit
        do_trap(9'h041, 3'd6, 3'd7, 3'd1, 3'd0);   // R3 level 7, slot 7

        picks = '{9'h024, 9'h060, 9'h008, 9'h030, 9'h064, 9'h06B, 9'h080,
                  9'h0BC, 9'h0C0, 9'h0F8, 9'h1FF, 9'h000};
        for (int n = 0; n < 400; n++) begin
            logic [8:0] tt;
            logic [2:0] mtl, tl;
            tt  = ($urandom % 3 == 0) ? picks[$urandom % 12] : 9'($urandom);
            mtl = 3'(1 + $urandom % 7);
            tl  = ($urandom % 4 == 0) ? mtl - 3'd1 : 3'($urandom);
            do_trap(tt, tl, mtl, 3'($urandom), 3'($urandom));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule